// File: doc/BRIEF.md
# Bit-Serial CRC Remainder Generator and Checker

This block forms a frame check sequence by polynomial long division over GF(2), one bit per clock. An N-bit remainder register is cleared, then fed a message most significant bit first. On the sending side the caller follows the message with N zero bits, and the register then holds the N-bit remainder that is appended to the frame. On the receiving side the whole frame, message followed by its check sequence, goes through the same logic, and a register of all zeros at the end marks the frame as clean.

The generator polynomial is a parameter. It is written as its N low-order coefficients, and the x^N term is implied. Each one bit in the parameter places an XOR in the feedback path at that position. The default is the 16-bit polynomial x^16+x^12+x^5+1. Deciding where a frame starts and ends, and which bits are message bits, is left to the logic around the block.

Top module: `crc_serial`

## Requirements
- R1: After reset, `crc_rem` is all zeros and `crc_err` is 0.
- R2: A cycle with `clr_i` high leaves `crc_rem` all zeros in the next cycle, even when `bit_vld` is also high.
- R3: A cycle with neither `clr_i` nor `bit_vld` high leaves `crc_rem` unchanged.
- R4: While the top bit of the register is 0, an accepted bit is a plain shift. The register moves up by one and the new bit enters at bit 0, so the register takes in bits most significant first. After a clear, the first N bits therefore appear unchanged in `crc_rem`.
- R5: When the top bit is 1, an accepted bit shifts as in R4, and the result is then XORed with the polynomial's low N coefficients. After a clear, a message followed by N zero bits leaves the mod-2 remainder of (message·x^N) divided by the generator. Example: generator 110101 with message 1010001101 gives remainder 01110.
- R6: The default parameters give N = 16 and generator x^16+x^12+x^5+1, written as POLY = 16'h1021.
- R7: After a clear, a message followed by its own remainder (MSB first) leaves `crc_rem` all zeros.
- R8: On a cycle with `chk_i` high, `crc_err` takes the value 1 in the next cycle if `crc_rem` was nonzero in that cycle, and 0 otherwise. `crc_err` holds its value until the next `chk_i`.
- R9: Any single flipped bit in a frame built as in R7 leaves a nonzero register, so a `chk_i` after that frame raises `crc_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Clear the remainder register |
| bit_vld | input | 1 | `bit_in` carries a bit to divide this cycle |
| bit_in | input | 1 | Serial data bit, most significant first |
| chk_i | input | 1 | Sample the register into the error flag |
| crc_rem | output | N | Current remainder register |
| crc_err | output | 1 | Register was nonzero at the last check |

## Verification
A 5-bit instance with generator 110101 is swept over every 10-bit message. Each message is run both as an augmented division and as a full received frame. This separates wrong tap positions, which corrupt the remainder, from wrong bit order, which passes the zero test only by chance. The 16-bit default instance takes messages of varied length and compares each against a long-division model in the bench. A first-16-bit run with no feedback isolates the plain shift. Each single-bit flip over a full frame shows the error flag responding to every position. Collisions of clear with valid bits, idle gaps and repeated checks pin down the priority rules and the holding behaviour.

// File: rtl/crc_pkg.sv
package crc_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_SHIFT = 2'd2
    } crc_op_e;

    // Clear outranks a valid bit in the same cycle.
    function automatic crc_op_e decode_op(input logic clr, input logic vld);
        if (clr)      return OP_CLEAR;
        else if (vld) return OP_SHIFT;
        else          return OP_IDLE;
    endfunction

endpackage

// File: rtl/crc_div_step.sv
module crc_div_step #(
    parameter int          N    = 16,
    parameter logic [N-1:0] POLY = 16'h1021
) (
    input  logic [N-1:0] cur,
    input  logic         din,
    output logic [N-1:0] nxt,
    output logic         fb
);
    assign fb = cur[N-1];

    // Bit 0 takes the incoming dividend bit; the others shift up.
    // An XOR sits only where the polynomial has a term.
    for (genvar i = 0; i < N; i++) begin : g_tap
        logic src;
        if (i == 0) begin : g_lsb
            assign src = din;
        end else begin : g_mid
            assign src = cur[i-1];
        end
        if (POLY[i]) begin : g_xor
            assign nxt[i] = src ^ fb;
        end else begin : g_wire
            assign nxt[i] = src;
        end
    end

    always_comb begin
        if (!$isunknown({cur, din}) && !fb) begin
            p_plain_shift_r4: assert (nxt == {cur[N-2:0], din})
                else $error("R4: step with top bit clear is not a plain shift");
        end
    end
endmodule

// File: rtl/crc_zero_detect.sv
module crc_zero_detect #(
    parameter int N = 16
) (
    input  logic [N-1:0] val,
    output logic         nonzero
);
    assign nonzero = |val;
endmodule

// File: rtl/crc_serial.sv
module crc_serial
    import crc_pkg::*;
#(
    parameter int           N    = 16,
    parameter logic [N-1:0] POLY = 16'h1021
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         bit_vld,
    input  logic         bit_in,
    input  logic         chk_i,
    output logic [N-1:0] crc_rem,
    output logic         crc_err
);
    localparam logic [N-1:0] ZERO = '0;

    typedef struct packed {
        logic [N-1:0] rem;
        logic         err;
    } state_t;

    state_t  st_d, st_q;
    crc_op_e op;
    logic [N-1:0] step_nxt;
    logic         step_fb;
    logic         rem_nz;

    crc_div_step #(.N(N), .POLY(POLY)) u_step (
        .cur (st_q.rem),
        .din (bit_in),
        .nxt (step_nxt),
        .fb  (step_fb)
    );

    crc_zero_detect #(.N(N)) u_nz (
        .val     (st_q.rem),
        .nonzero (rem_nz)
    );

    assign op = decode_op(clr_i, bit_vld);

    always_comb begin
        st_d = st_q;
        case (op)
            OP_CLEAR: st_d.rem = ZERO;
            OP_SHIFT: st_d.rem = step_nxt;
            default:  st_d.rem = st_q.rem;
        endcase
        if (chk_i) st_d.err = rem_nz;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign crc_rem = st_q.rem;
    assign crc_err = st_q.err;

    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> crc_rem == ZERO)
        else $error("R2: clear did not zero the register");

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !bit_vld) |=> $stable(crc_rem))
        else $error("R3: register moved without a valid bit");

    p_feedback_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && !clr_i && crc_rem[N-1])
            |=> crc_rem != {$past(crc_rem[N-2:0]), $past(bit_in)})
        else $error("R5: top bit set but no feedback applied");

    p_err_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
        chk_i |=> crc_err == ($past(crc_rem) != ZERO))
        else $error("R8: error flag does not match checked register");

    p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_i |=> $stable(crc_err))
        else $error("R8: error flag changed without a check");
endmodule

// File: tb/crc_serial_test.sv
module crc_serial_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic a_clr = 0, a_vld = 0, a_bit = 0, a_chk = 0;
    logic b_clr = 0, b_vld = 0, b_bit = 0, b_chk = 0;
    logic [15:0] a_rem;
    logic        a_err;
    logic [4:0]  b_rem;
    logic        b_err;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    crc_serial uut (
        .clk(clk), .rst_n(rst_n), .clr_i(a_clr), .bit_vld(a_vld),
        .bit_in(a_bit), .chk_i(a_chk), .crc_rem(a_rem), .crc_err(a_err)
    );

    crc_serial #(.N(5), .POLY(5'b10101)) uut5 (
        .clk(clk), .rst_n(rst_n), .clr_i(b_clr), .bit_vld(b_vld),
        .bit_in(b_bit), .chk_i(b_chk), .crc_rem(b_rem), .crc_err(b_err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            tests++; fails++;
            $display("FAIL watchdog: run hung, act=%0d exp<190000", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    // Long division of msg*x^n by gen (gen includes the x^n term).
    function automatic logic [15:0] model_rem(input logic [47:0] msg, input int len,
                                              input int n, input logic [16:0] gen);
        logic [63:0] a;
        a = 64'(msg) << n;
        for (int i = len + n - 1; i >= n; i--)
            if (a[i]) a = a ^ (64'(gen) << (i - n));
        return 16'(a & ((64'd1 << n) - 1));
    endfunction

    // All drive tasks start and end at a falling edge.
    task automatic drive(input int sel, input logic c, input logic v, input logic b, input logic k);
        if (sel == 0) begin a_clr = c; a_vld = v; a_bit = b; a_chk = k; end
        else          begin b_clr = c; b_vld = v; b_bit = b; b_chk = k; end
        @(negedge clk);
        a_clr = 0; a_vld = 0; a_bit = 0; a_chk = 0;
        b_clr = 0; b_vld = 0; b_bit = 0; b_chk = 0;
    endtask

    task automatic do_clear(input int sel); drive(sel, 1, 0, 0, 0); endtask
    task automatic do_bit(input int sel, input logic b); drive(sel, 0, 1, b, 0); endtask
    task automatic do_chk(input int sel); drive(sel, 0, 0, 0, 1); endtask
    task automatic do_idle(input int sel); drive(sel, 0, 0, 0, 0); endtask

    task automatic feed(input int sel, input logic [47:0] v, input int len);
        for (int i = len - 1; i >= 0; i--) do_bit(sel, v[i]);
    endtask

    function automatic logic [15:0] rem_of(input int sel);
        return (sel == 0) ? a_rem : 16'(b_rem);
    endfunction

    function automatic logic err_of(input int sel);
        return (sel == 0) ? a_err : b_err;
    endfunction

    initial begin
        logic [15:0] fcs;
        logic [15:0] held;
        logic [47:0] frame;
        logic [31:0] lcg;

        repeat (3) @(negedge clk);
        check("R1 reset rem16", a_rem, 16'h0);
        check("R1 reset err16", 16'(a_err), 16'h0);
        check("R1 reset rem5", 16'(b_rem), 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release rem16", a_rem, 16'h0);
        check("R1 after release err5", 16'(b_err), 16'h0);

        // R5 worked example: 110101 over 1010001101 -> 01110
        do_clear(1);
        feed(1, 48'b1010001101, 10);
        feed(1, 48'h0, 5);
        check("R5 example remainder", 16'(b_rem), 16'b01110);
        // R7 example frame 101000110101110
        do_clear(1);
        feed(1, 48'b101000110101110, 15);
        check("R7 example frame rem", 16'(b_rem), 16'h0);
        do_chk(1);
        check("R7 R8 example frame err", 16'(b_err), 16'h0);

        // R4 plain shift: first bits after clear appear unchanged
        do_clear(1);
        feed(1, 48'b1011, 4);
        check("R4 5-bit shift of 1011", 16'(b_rem), 16'b01011);
        do_clear(0);
        feed(0, 48'hB3C5, 16);
        check("R4 16-bit shift of 16 bits", a_rem, 16'hB3C5);
        // R6: 17th bit 0 with top=1 -> (B3C5<<1)^1021 on low 16 bits
        do_bit(0, 1'b0);
        check("R6 default poly feedback", a_rem, 16'h678A ^ 16'h1021);

        // R3 hold over idle cycles
        held = a_rem;
        repeat (4) do_idle(0);
        check("R3 idle hold", a_rem, held);

        // R2 clear wins over a valid bit
        drive(0, 1, 1, 1, 0);
        check("R2 clear with valid bit", a_rem, 16'h0);

        // R8 flag rises on nonzero and holds
        feed(0, 48'h3, 2);
        do_chk(0);
        check("R8 err on nonzero", 16'(a_err), 16'h1);
        feed(0, 48'h5, 3);
        do_clear(0);
        check("R8 err holds without check", 16'(a_err), 16'h1);
        do_chk(0);
        check("R8 err cleared by check on zero", 16'(a_err), 16'h0);

        // Exhaustive 10-bit messages through the 5-bit instance (R5, R7)
        for (int m = 0; m < 1024; m++) begin
            fcs = model_rem(48'(m), 10, 5, 17'b110101);
            do_clear(1);
            feed(1, 48'(m), 10);
            feed(1, 48'h0, 5);
            check($sformatf("R5 sweep5 msg=%0d", m), 16'(b_rem), fcs);
            do_clear(1);
            feed(1, 48'(m), 10);
            feed(1, 48'(fcs), 5);
            do_chk(1);
            check($sformatf("R7 sweep5 msg=%0d", m), 16'(b_err), 16'h0);
        end

        // Varied-length messages through the 16-bit default (R5, R6, R7)
        lcg = 32'h1234_5678;
        for (int k = 0; k < 64; k++) begin
            int len;
            logic [47:0] msg;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            len = 8 + (k % 25);
            msg = 48'(lcg) & ((48'd1 << len) - 1);
            fcs = model_rem(msg, len, 16, 17'h11021);
            do_clear(0);
            feed(0, msg, len);
            feed(0, 48'h0, 16);
            check($sformatf("R5 R6 sweep16 k=%0d", k), a_rem, fcs);
            do_clear(0);
            feed(0, msg, len);
            feed(0, 48'(fcs), 16);
            check($sformatf("R7 sweep16 k=%0d", k), a_rem, 16'h0);
        end

        // R9 single-bit errors over a 48-bit frame
        fcs = model_rem(48'hA5C30F1E, 32, 16, 17'h11021);
        for (int j = 0; j < 48; j++) begin
            frame = {16'h0, 32'hA5C30F1E} << 16;
            frame = frame | 48'(fcs);
            frame[j] = ~frame[j];
            do_clear(0);
            feed(0, frame, 48);
            do_chk(0);
            check($sformatf("R9 flip16 pos=%0d", j), 16'(a_err), 16'h1);
        end
        for (int j = 0; j < 15; j++) begin
            frame = 48'b101000110101110;
            frame[j] = ~frame[j];
            do_clear(1);
            feed(1, frame, 15);
            do_chk(1);
            check($sformatf("R9 flip5 pos=%0d", j), 16'(err_of(1)), 16'h1);
        end
        check("R9 5-bit rem nonzero after flip", 16'(rem_of(1) != 16'h0), 16'h1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule